// File: doc/BRIEF.md
# Timer Capture/Compare Channel

One channel of a timer. It sits beside a shared free-running counter and works in one of four modes. In capture mode it watches an external pin through a synchronizer. When the chosen kind of edge appears, it stores the counter value and raises its event flag. In compare mode and in the two PWM modes it compares the counter with its own value register. It raises the flag when the two are equal, once for each counter value.

Software sees the flag through a small read/write handshake. The flag is cleared only by a read that finds it set, followed later by a write of 0. An event that arrives between those two steps cancels the clear. The interrupt output is the flag gated by the channel enable.

Top module: `chan_capcmp`

## Requirements
- R1: Mode encoding is 00 capture, 01 compare, 10 edge PWM and 11 center PWM. In capture mode the 2-bit edge select picks the trigger: 00 none, 01 rising, 10 falling, 11 either. A selected edge sets the flag, and an unselected edge does not.
- R2: The pin passes through two synchronizer flops. A pin change applied before clock edge k is captured at edge k+2, and the stored value is the counter value present at that edge. The capture register changes at no other time, and the pin has no effect outside capture mode.
- R3: In modes 01, 10 and 11 the flag sets one clock after the counter input equals the channel value register.
- R4: While the counter holds one value for several clocks, a match sets the flag only once. After a clear, the flag stays 0 until the counter value changes.
- R5: The interrupt output is 1 exactly when the flag is 1 and the interrupt enable is 1.
- R6: The flag clears on the clock after a write of 0. That write must follow a read strobe that was issued while the flag was 1.
- R7: An event that occurs after the arming read and before the write of 0 cancels the clear, and the flag stays 1.
- R8: A write of 1, or a write of 0 with no arming read before it, leaves the flag at 1.
- R9: After reset the flag, the interrupt, the captured value and the value register are all 0.
- R10: A write strobe on the value port loads the value register at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Shared counter value |
| mode_i | input | 2 | Channel mode |
| edge_sel_i | input | 2 | Capture edge select |
| val_we_i | input | 1 | Value register write strobe |
| val_wdata_i | input | CNT_W | Value register write data |
| pin_i | input | 1 | Asynchronous capture pin |
| irq_en_i | input | 1 | Interrupt enable |
| flag_rd_i | input | 1 | Flag read strobe |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write data |
| capt_o | output | CNT_W | Captured counter value |
| flag_o | output | 1 | Event flag |
| irq_o | output | 1 | Interrupt level |

## Verification
A wrong arm bit shows as a flag that survives a proper clear, or one that drops after a bare write of 0. This is visible one clock after the write. A stale match history shows as a flag that reappears while the counter still holds the matched value, within one clock of the clear. A fault in the synchronizer or edge decoder shows two clocks after the pin change, as a captured value off by the wrong number of counter steps or as a flag raised on the wrong edge.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
   typedef enum logic [1:0] {
      CH_CAPTURE    = 2'b00,
      CH_COMPARE    = 2'b01,
      CH_PWM_EDGE   = 2'b10,
      CH_PWM_CENTER = 2'b11
   } ch_mode_e;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;
endpackage

// File: rtl/chan_pin_edge.sv
module chan_pin_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic [1:0] sel_i,
   output logic       evt_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   lvl;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("chan_pin_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign lvl = sync_q[SYNC_STAGES-1];

   always_comb begin
      evt_o = 1'b0;
      if (lvl && !last_q)  evt_o = sel_i[0];
      if (!lvl && last_q)  evt_o = sel_i[1];
   end
endmodule

// File: rtl/chan_cmp_match.sv
module chan_cmp_match #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             evt_o
);
   logic             hit;
   logic             hit_q;
   logic [CNT_W-1:0] cnt_q;

   assign hit   = en_i && (cnt_i == val_i);
   assign evt_o = hit && !(hit_q && (cnt_q == cnt_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         hit_q <= hit;
         cnt_q <= cnt_i;
      end
   end
endmodule

// File: rtl/chan_evt_flag.sv
module chan_evt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wdata_i,
   output logic flag_o
);
   logic flag_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (evt_i) begin
         flag_q  <= 1'b1;
         armed_q <= 1'b0;
      end else if (wr_i && !wdata_i && armed_q) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (rd_i && flag_q) begin
         armed_q <= 1'b1;
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/chan_capcmp.sv
module chan_capcmp
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [1:0]       mode_i,
   input  logic [1:0]       edge_sel_i,
   input  logic             val_we_i,
   input  logic [CNT_W-1:0] val_wdata_i,
   input  logic             pin_i,
   input  logic             irq_en_i,
   input  logic             flag_rd_i,
   input  logic             flag_wr_i,
   input  logic             flag_wdata_i,
   output logic [CNT_W-1:0] capt_o,
   output logic             flag_o,
   output logic             irq_o
);
   logic             is_capt;
   logic [1:0]       eff_sel;
   logic             pin_evt;
   logic             cmp_evt;
   logic [CNT_W-1:0] val_q;
   logic [CNT_W-1:0] capt_q;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("chan_capcmp: CNT_W must be at least 2");
      end
   endgenerate

   assign is_capt = (mode_i == CH_CAPTURE);
   assign eff_sel = is_capt ? edge_sel_i : EDGE_OFF;

   chan_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_i),
      .sel_i (eff_sel),
      .evt_o (pin_evt)
   );

   chan_cmp_match #(.CNT_W(CNT_W)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (!is_capt),
      .cnt_i (cnt_i),
      .val_i (val_q),
      .evt_o (cmp_evt)
   );

   chan_evt_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (pin_evt || cmp_evt),
      .rd_i    (flag_rd_i),
      .wr_i    (flag_wr_i),
      .wdata_i (flag_wdata_i),
      .flag_o  (flag_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         capt_q <= '0;
      end else begin
         if (val_we_i) val_q  <= val_wdata_i;
         if (pin_evt)  capt_q <= cnt_i;
      end
   end

   assign capt_o = capt_q;
   assign irq_o  = flag_o && irq_en_i;
endmodule

// File: rtl/chan_capcmp_chk.sv
module chan_capcmp_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt_i,
   input logic [1:0]       mode_i,
   input logic [1:0]       edge_sel_i,
   input logic             irq_en_i,
   input logic             flag_wr_i,
   input logic             flag_wdata_i,
   input logic [CNT_W-1:0] capt_o,
   input logic             flag_o,
   input logic             irq_o,
   input logic             cmp_evt
);
   logic live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   // R6
   flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(flag_wr_i && !flag_wdata_i));

   // R8
   write_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && flag_wr_i && flag_wdata_i) |=> flag_o);

   // R5
   irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && irq_en_i) |-> irq_o);

   // R5
   irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o || !irq_en_i) |-> !irq_o);

   // R2
   capt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(capt_o) |-> ($past(mode_i) == 2'b00 && $past(edge_sel_i) != 2'b00));

   // R1
   off_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag_o) && $past(mode_i) == 2'b00) |-> $past(edge_sel_i) != 2'b00);

   // R4
   once_per_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && cmp_evt && $past(cmp_evt)) |-> cnt_i != $past(cnt_i));
endmodule

bind chan_capcmp chan_capcmp_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cnt_i        (cnt_i),
   .mode_i       (mode_i),
   .edge_sel_i   (edge_sel_i),
   .irq_en_i     (irq_en_i),
   .flag_wr_i    (flag_wr_i),
   .flag_wdata_i (flag_wdata_i),
   .capt_o       (capt_o),
   .flag_o       (flag_o),
   .irq_o        (irq_o),
   .cmp_evt      (cmp_evt)
);

// File: tb/chan_capcmp_bench.sv
module chan_capcmp_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] cnt = '0;
   logic [1:0]   mode = 2'b00;
   logic [1:0]   esel = 2'b00;
   logic         val_we = 1'b0;
   logic [W-1:0] val_wd = '0;
   logic         pin = 1'b0;
   logic         irq_en = 1'b0;
   logic         rd = 1'b0;
   logic         wr = 1'b0;
   logic         wd = 1'b0;
   logic [W-1:0] capt;
   logic         flag;
   logic         irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   chan_capcmp #(.CNT_W(W), .SYNC_STAGES(2)) u_chan_capcmp (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .mode_i(mode), .edge_sel_i(esel),
      .val_we_i(val_we), .val_wdata_i(val_wd), .pin_i(pin), .irq_en_i(irq_en),
      .flag_rd_i(rd), .flag_wr_i(wr), .flag_wdata_i(wd),
      .capt_o(capt), .flag_o(flag), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic clear_flag();
      tick(); rd = 1'b1;
      tick(); rd = 1'b0; wr = 1'b1; wd = 1'b0;
      tick(); wr = 1'b0;
   endtask

   task automatic set_val(input logic [W-1:0] v);
      tick(); val_we = 1'b1; val_wd = v;
      tick(); val_we = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [W-1:0] exp_capt;
      logic         sel;
      repeat (3) tick();
      // R9 reset state
      chk("R9 flag", flag, 0);
      chk("R9 irq", irq, 0);
      chk("R9 capt", capt, 0);
      rst_n = 1'b1;
      tick();
      // R9/R10: value register is 0 after reset, so compare hits at count 0
      mode = 2'b01; cnt = 16'd0;
      tick();
      chk("R9 R10 reset value matches 0", flag, 1);
      clear_flag();
      chk("R6 clear", flag, 0);

      // R3 R4 R10 sweep over modes, values and counts
      for (int m = 1; m < 4; m++) begin
         for (int vi = 0; vi < 3; vi++) begin
            logic [W-1:0] v;
            v = (vi == 0) ? 16'd3 : (vi == 1) ? 16'd7 : 16'd19;
            tick(); mode = m[1:0]; cnt = 16'hFFF0;
            set_val(v);
            for (int c = 0; c < 20; c++) begin
               cnt = c[W-1:0];
               tick();
               chk("R3 match flag", flag, (c[W-1:0] == v));
               if (flag) begin
                  clear_flag();
                  tick(); tick();
                  chk("R4 no refire on held count", flag, 0);
               end
            end
         end
      end

      // R1 R2 capture sweep over edge selects
      mode = 2'b00;
      exp_capt = capt;
      for (int es = 0; es < 4; es++) begin
         esel = es[1:0];
         tick();
         for (int t = 0; t < 4; t++) begin
            logic [W-1:0] v0;
            pin = ~pin; cnt = cnt + 1'b1; v0 = cnt;
            sel = pin ? es[0] : es[1];
            tick(); cnt = cnt + 1'b1;
            tick(); cnt = cnt + 1'b1;
            tick();
            if (sel) exp_capt = v0 + 16'd2;
            chk("R1 edge flag", flag, sel);
            chk("R2 captured value", capt, exp_capt);
            if (flag) clear_flag();
         end
      end

      // R2 pin ignored in compare mode
      mode = 2'b01; set_val(16'hFFFF); cnt = 16'd100;
      for (int t = 0; t < 2; t++) begin
         tick(); pin = ~pin;
         tick(); tick(); tick();
         chk("R2 pin ignored flag", flag, 0);
         chk("R2 pin ignored capt", capt, exp_capt);
      end

      // R8 write 0 without read, write 1 after read
      set_val(16'd50); cnt = 16'd50; tick();
      chk("R3 set", flag, 1);
      cnt = 16'd51;
      wr = 1'b1; wd = 1'b0; tick(); wr = 1'b0; tick();
      chk("R8 write0 unarmed", flag, 1);
      rd = 1'b1; tick(); rd = 1'b0; wr = 1'b1; wd = 1'b1; tick(); wr = 1'b0; tick();
      chk("R8 write1 armed", flag, 1);
      // R7 event between read and write
      rd = 1'b1; tick(); rd = 1'b0; cnt = 16'd50; tick(); cnt = 16'd51;
      wr = 1'b1; wd = 1'b0; tick(); wr = 1'b0; tick();
      chk("R7 new event keeps flag", flag, 1);
      // R5 interrupt level
      irq_en = 1'b1; tick();
      chk("R5 irq on", irq, 1);
      irq_en = 1'b0; tick();
      chk("R5 irq off by enable", irq, 0);
      irq_en = 1'b1;
      clear_flag();
      chk("R6 clear after event", flag, 0);
      chk("R5 irq off by flag", irq, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule